// File: doc/BRIEF.md
# GPIO Expander Alert Controller

This block is the register and alert core of a general-purpose I/O expander with two ports of eight pins each. Software reaches it through a plain synchronous register port: it sets each pin's direction, output value and drive style, and reads back the pin levels after they pass a two-stage synchronizer. The block drives three per-pin pad controls: output value, output enable and open-drain select.

Each pin can raise an alert on a rising edge, a falling edge, both edges, or a high or low level. Level mode applies when both edge enables of a pin are clear. Alerts latch into write-1-to-clear status bits. A status bit ANDed with its mask bit is a pending alert. Any pending alert sets one vendor-defined bit in a summary alert register. That bit has its own write-1-to-clear and its own mask, and it drives an active-low shared alert line.

Port 0 pins start on their alternate function, and a mux register switches each pin to GPIO use. A variant code is a parameter and can be read from an identity register. The code 3'b010 gives a reduced part with only port 0.

Top module: `gpio_alert_ctrl`

Register map (8-bit addresses, data width PW = 8). For per-port registers, address bit 0 selects the port. Identity 0x00 (read-only). Mux 0x02. Summary alert 0x04/0x05. Summary mask 0x06/0x07. Direction 0x10/0x11. Output data 0x12/0x13. Input data 0x14/0x15 (read-only). Drive select 0x16/0x17. Rise enable 0x18/0x19. Fall enable 0x1A/0x1B. Level polarity 0x1C/0x1D. Alert mask 0x1E/0x1F. Alert status 0x20/0x21. Unmapped addresses read 0.

## Requirements
- R1: While reset is held, every register reads 0, pin_oe is 0, alert_n is 1 and alt_sel is all ones.
- R2: pin_out follows the output-data registers. A pin's enable is set only when its direction bit is 1 (output), except that a pin with drive select 1 (open-drain) and output data 1 is released. Drive select 0 means push-pull, and pin_od mirrors the drive-select bits.
- R3: The input-data registers (0x14/0x15) return pin_in after a two-flop synchronizer, so a pin change becomes readable two clock edges later.
- R4: With the rise-enable bit at 1, a 0-to-1 transition of the synchronized pin sets that pin's status bit. A pin that stays high does not set it again after a clear.
- R5: With the fall-enable bit at 1, a 1-to-0 transition sets the status bit. With both enables at 1, either transition sets it.
- R6: When both edge enables of a pin are 0, the pin alerts on level. Level polarity 1 alerts while the pin is high, and 0 alerts while it is low. A status bit cleared while its level condition still holds sets again on the next clock.
- R7: Writing 1 to a status bit (0x20 for port 0, 0x21 for port 1) clears it, and writing 0 leaves it unchanged. Each port's status register is independent.
- R8: Bit 7 of 0x05 is the vendor-defined summary bit. It sets on the clock after any status bit AND its mask bit is 1. Writing 1 to it clears it only when no alert is pending.
- R9: alert_n is 0 exactly while the vendor-defined bit and the summary mask bit (bit 7 of 0x07) are both 1.
- R10: Register 0x02 holds one bit per port-0 pin, where 1 selects GPIO use. alt_sel is its inverse.
- R11: Bits [4:2] of the identity register 0x00 return the VARIANT parameter, and its other bits read 0.
- R12: With VARIANT = 3'b010, writes to port-1 registers are ignored and their reads return 0. Port 1 never enables a pad and never raises the summary bit, while port 0 still works.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register address |
| reg_we | input | 1 | Write strobe, acts at the clock edge |
| reg_wdata | input | PW | Write data |
| reg_rdata | output | PW | Read data for reg_addr, combinational |
| pin_in | input | 2*PW | Pad input levels, port 1 in the upper byte |
| pin_out | output | 2*PW | Pad output values |
| pin_oe | output | 2*PW | Pad output enables |
| pin_od | output | 2*PW | Pad open-drain selects |
| alt_sel | output | PW | 1 where a port-0 pin is on its alternate function |
| alert_n | output | 1 | Active-low shared alert |

## Verification
The bench clears a level-mode status bit while the level still holds and expects it to return at once. A design that gave clear priority without re-evaluating the level would leave the bit empty. It also clears the vendor bit while an alert is still pending and expects the bit to stay set; a plain flop clear would drop the alert line with work outstanding. A rise-enabled pin is held high after a clear to catch logic that treats an edge mode as a level. A write of zeros to status is checked to confirm it does not act as a plain store. A second instance of the reduced variant receives the same writes and pin stimulus, so a port-1 register or alert that leaks through in that variant shows up as an enabled pad, a nonzero read or a low alert line.

// File: rtl/gx_pkg.sv
package gx_pkg;
  localparam logic [7:0] A_IDENT  = 8'h00;
  localparam logic [7:0] A_MUX    = 8'h02;
  localparam logic [7:0] A_SUM_HI = 8'h05;
  localparam logic [7:0] A_SMK_HI = 8'h07;
  // per-port function codes, address = {code, port}
  localparam logic [6:0] F_DIR  = 7'h08;
  localparam logic [6:0] F_DOUT = 7'h09;
  localparam logic [6:0] F_DIN  = 7'h0A;
  localparam logic [6:0] F_OD   = 7'h0B;
  localparam logic [6:0] F_RISE = 7'h0C;
  localparam logic [6:0] F_FALL = 7'h0D;
  localparam logic [6:0] F_LVL  = 7'h0E;
  localparam logic [6:0] F_MSK  = 7'h0F;
  localparam logic [6:0] F_STAT = 7'h10;
  localparam logic [2:0] VAR_LITE = 3'b010;
endpackage

// File: rtl/gx_sync.sv
module gx_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gx_alert_cell.sv
// Per-pin alert detection and sticky status for one port.
module gx_alert_cell #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_now,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  input  logic [W-1:0] lvl_hi,
  input  logic [W-1:0] clr,
  output logic [W-1:0] status
);
  logic [W-1:0] lvl_prev;
  logic [W-1:0] edge_hit;
  logic [W-1:0] level_hit;

  always_comb begin
    edge_hit  = (rise_en & lvl_now & ~lvl_prev) | (fall_en & ~lvl_now & lvl_prev);
    level_hit = ~(rise_en | fall_en) & ~(lvl_now ^ lvl_hi);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_prev <= '0;
      status   <= '0;
    end else begin
      lvl_prev <= lvl_now;
      // edges are never lost to a clear; a held level returns one clock later
      status   <= (status & ~clr) | edge_hit | (level_hit & ~clr);
    end
  end
endmodule

// File: rtl/gx_alert_summary.sv
// Vendor-defined summary bit, its mask and the shared alert line.
module gx_alert_summary (
  input  logic clk,
  input  logic rst_n,
  input  logic pend_any,
  input  logic vend_clr,
  input  logic msk_we,
  input  logic msk_d,
  output logic vend,
  output logic vmsk,
  output logic alert_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vend <= 1'b0;
      vmsk <= 1'b0;
    end else begin
      vend <= pend_any | (vend & ~vend_clr);
      if (msk_we) vmsk <= msk_d;
    end
  end

  assign alert_n = ~(vend & vmsk);
endmodule

// File: rtl/gpio_alert_ctrl.sv
module gpio_alert_ctrl
  import gx_pkg::*;
#(
  parameter int         PW      = 8,
  parameter logic [2:0] VARIANT = 3'b000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      reg_addr,
  input  logic            reg_we,
  input  logic [PW-1:0]   reg_wdata,
  output logic [PW-1:0]   reg_rdata,
  input  logic [2*PW-1:0] pin_in,
  output logic [2*PW-1:0] pin_out,
  output logic [2*PW-1:0] pin_oe,
  output logic [2*PW-1:0] pin_od,
  output logic [PW-1:0]   alt_sel,
  output logic            alert_n
);
  localparam int NP   = 2;
  localparam bit LITE = (VARIANT == VAR_LITE);

  logic [6:0]           fcode;
  logic [NP*PW-1:0]     dir_flat, dout_flat, od_flat, stat_flat, msk_flat;
  logic [NP-1:0][PW-1:0] rd_port;
  logic [NP-1:0]        pend;
  logic [PW-1:0]        mux_r;
  logic                 vend_q, vmsk_q;

  assign fcode = reg_addr[7:1];

  genvar p;
  generate
    for (p = 0; p < NP; p++) begin : g_port
      localparam bit LIVE = (p == 0) || !LITE;
      logic [PW-1:0] dir_r, dout_r, od_r, rise_r, fall_r, lvl_r, msk_r;
      logic [PW-1:0] sync_q, stat_q, clr;
      logic          wr_ok;

      assign wr_ok = LIVE && reg_we && (reg_addr[0] == p[0]);
      assign clr   = (wr_ok && fcode == F_STAT) ? reg_wdata : '0;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dir_r  <= '0;
          dout_r <= '0;
          od_r   <= '0;
          rise_r <= '0;
          fall_r <= '0;
          lvl_r  <= '0;
          msk_r  <= '0;
        end else if (wr_ok) begin
          case (fcode)
            F_DIR:   dir_r  <= reg_wdata;
            F_DOUT:  dout_r <= reg_wdata;
            F_OD:    od_r   <= reg_wdata;
            F_RISE:  rise_r <= reg_wdata;
            F_FALL:  fall_r <= reg_wdata;
            F_LVL:   lvl_r  <= reg_wdata;
            F_MSK:   msk_r  <= reg_wdata;
            default: ;
          endcase
        end
      end

      gx_sync #(.W(PW)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in[p*PW +: PW]), .q(sync_q)
      );

      gx_alert_cell #(.W(PW)) u_cell (
        .clk(clk), .rst_n(rst_n), .lvl_now(sync_q), .rise_en(rise_r),
        .fall_en(fall_r), .lvl_hi(lvl_r), .clr(clr), .status(stat_q)
      );

      assign pend[p] = LIVE && (|(stat_q & msk_r));

      always_comb begin
        rd_port[p] = '0;
        if (LIVE) begin
          case (fcode)
            F_DIR:   rd_port[p] = dir_r;
            F_DOUT:  rd_port[p] = dout_r;
            F_DIN:   rd_port[p] = sync_q;
            F_OD:    rd_port[p] = od_r;
            F_RISE:  rd_port[p] = rise_r;
            F_FALL:  rd_port[p] = fall_r;
            F_LVL:   rd_port[p] = lvl_r;
            F_MSK:   rd_port[p] = msk_r;
            F_STAT:  rd_port[p] = stat_q;
            default: rd_port[p] = '0;
          endcase
        end
      end

      assign dir_flat[p*PW +: PW]  = dir_r;
      assign dout_flat[p*PW +: PW] = dout_r;
      assign od_flat[p*PW +: PW]   = od_r;
      assign stat_flat[p*PW +: PW] = stat_q;
      assign msk_flat[p*PW +: PW]  = msk_r;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               mux_r <= '0;
    else if (reg_we && reg_addr == A_MUX)     mux_r <= reg_wdata;
  end

  gx_alert_summary u_sum (
    .clk(clk), .rst_n(rst_n), .pend_any(|pend),
    .vend_clr(reg_we && reg_addr == A_SUM_HI && reg_wdata[PW-1]),
    .msk_we(reg_we && reg_addr == A_SMK_HI), .msk_d(reg_wdata[PW-1]),
    .vend(vend_q), .vmsk(vmsk_q), .alert_n(alert_n)
  );

  always_comb begin
    reg_rdata = '0;
    if (fcode >= F_DIR && fcode <= F_STAT) begin
      reg_rdata = rd_port[reg_addr[0]];
    end else begin
      case (reg_addr)
        A_IDENT:  reg_rdata[4:2]    = VARIANT;
        A_MUX:    reg_rdata         = mux_r;
        A_SUM_HI: reg_rdata[PW-1]   = vend_q;
        A_SMK_HI: reg_rdata[PW-1]   = vmsk_q;
        default:  reg_rdata         = '0;
      endcase
    end
  end

  assign pin_out = dout_flat;
  assign pin_od  = od_flat;
  assign pin_oe  = dir_flat & ~(od_flat & dout_flat);
  assign alt_sel = ~mux_r;
endmodule

// File: rtl/gpio_alert_ctrl_chk.sv
module gpio_alert_ctrl_chk #(
  parameter int PW   = 8,
  parameter bit LITE = 1'b0
) (
  input logic            clk,
  input logic            rst_n,
  input logic [7:0]      reg_addr,
  input logic            reg_we,
  input logic [PW-1:0]   reg_wdata,
  input logic [2*PW-1:0] pin_oe,
  input logic [2*PW-1:0] pin_out,
  input logic [2*PW-1:0] dir_flat,
  input logic [2*PW-1:0] od_flat,
  input logic [2*PW-1:0] stat_flat,
  input logic [2*PW-1:0] msk_flat,
  input logic            vend_q,
  input logic            alert_n
);
  logic vend_clr_req;
  assign vend_clr_req = reg_we && reg_addr == 8'h05 && reg_wdata[PW-1];

  // R2: an enabled pad must be an output
  assert_oe_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & ~dir_flat) == '0);

  // R2: an open-drain pin driving 1 is released
  assert_od_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & od_flat & pin_out) == '0);

  // R9: alert line low only with the vendor bit set
  assert_alert_vendor_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !alert_n |-> vend_q);

  // R8: vendor bit holds without a clear request
  assert_vendor_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vend_q && !vend_clr_req) |=> vend_q);

  // R8: a masked-in status bit raises the vendor bit next clock
  assert_vendor_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat_flat[PW-1:0] & msk_flat[PW-1:0])) |=> vend_q);

  generate
    if (LITE) begin : g_lite
      // R12: reduced variant never enables a port-1 pad
      assert_lite_port1_R12: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe[2*PW-1:PW] == '0);
    end
  endgenerate
endmodule

bind gpio_alert_ctrl gpio_alert_ctrl_chk #(.PW(PW), .LITE(LITE)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .pin_oe(pin_oe), .pin_out(pin_out),
  .dir_flat(dir_flat), .od_flat(od_flat), .stat_flat(stat_flat),
  .msk_flat(msk_flat), .vend_q(vend_q), .alert_n(alert_n)
);

// File: tb/tb_gpio_alert_ctrl.sv
module tb_gpio_alert_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic we = 1'b0;
  logic [PW-1:0] wdata = '0;
  logic [2*PW-1:0] pin_in = '0;
  logic [PW-1:0] rdata, rdata_l, alt, alt_l;
  logic [2*PW-1:0] pout, poe, pod, pout_l, poe_l, pod_l;
  logic alert_n, alert_n_l;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_alert_ctrl #(.PW(PW), .VARIANT(3'b000)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_we(we), .reg_wdata(wdata),
    .reg_rdata(rdata), .pin_in(pin_in), .pin_out(pout), .pin_oe(poe),
    .pin_od(pod), .alt_sel(alt), .alert_n(alert_n));

  gpio_alert_ctrl #(.PW(PW), .VARIANT(3'b010)) dut_lite (
    .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_we(we), .reg_wdata(wdata),
    .reg_rdata(rdata_l), .pin_in(pin_in), .pin_out(pout_l), .pin_oe(poe_l),
    .pin_od(pod_l), .alt_sel(alt_l), .alert_n(alert_n_l));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [PW-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input bit lite, input logic [7:0] a, output logic [PW-1:0] v);
    @(negedge clk);
    addr = a;
    #1 v = lite ? rdata_l : rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [PW-1:0] v;
    addr = 8'h10; #1 v = rdata; chk("R1 dir", v, 0);
    addr = 8'h20; #1 v = rdata; chk("R1 status", v, 0);
    addr = 8'h05; #1 v = rdata; chk("R1 vendor", v, 0);
    chk("R1 oe", poe, 0);
    chk("R1 alert_n", alert_n, 1);
    chk("R1 alt_sel", alt, 8'hFF);
  endtask

  task automatic t_ident;
    logic [PW-1:0] v;
    rd(0, 8'h00, v); chk("R11 ident full", v, 8'h00);
    rd(1, 8'h00, v); chk("R11 ident lite", v, 8'h08);
  endtask

  task automatic t_drive;
    wr(8'h10, 8'hF0); wr(8'h12, 8'hAA); wr(8'h16, 8'h30);
    settle(1);
    chk("R2 pin_out", pout[7:0], 8'hAA);
    chk("R2 pin_oe", poe[7:0], 8'hD0);
    chk("R2 pin_od", pod[7:0], 8'h30);
  endtask

  task automatic t_din;
    logic [PW-1:0] v;
    @(negedge clk); pin_in[7:0] = 8'h5A;
    #1 v = rdata; addr = 8'h14; #1 v = rdata;
    chk("R3 not yet visible", v, 8'h00);
    settle(3);
    rd(0, 8'h14, v); chk("R3 din", v, 8'h5A);
    @(negedge clk); pin_in[7:0] = 8'h00;
    settle(4);
  endtask

  task automatic t_rise;
    logic [PW-1:0] v;
    wr(8'h18, 8'h05); wr(8'h1A, 8'h06); wr(8'h1C, 8'h08);
    settle(3);
    wr(8'h20, 8'hFF);
    rd(0, 8'h20, v); chk("R4 clear idle", v & 8'h01, 0);
    @(negedge clk); pin_in[0] = 1'b1;
    settle(5);
    rd(0, 8'h20, v); chk("R4 rise sets", v & 8'h01, 8'h01);
    wr(8'h20, 8'h01); settle(3);
    rd(0, 8'h20, v); chk("R4 held high no reset", v & 8'h01, 0);
  endtask

  task automatic t_fall;
    logic [PW-1:0] v;
    @(negedge clk); pin_in[1] = 1'b1; pin_in[2] = 1'b1;
    settle(5);
    wr(8'h20, 8'h06);
    rd(0, 8'h20, v); chk("R5 cleared", v & 8'h06, 0);
    @(negedge clk); pin_in[1] = 1'b0; pin_in[2] = 1'b0;
    settle(5);
    rd(0, 8'h20, v); chk("R5 fall sets both pins", v & 8'h06, 8'h06);
  endtask

  task automatic t_level;
    logic [PW-1:0] v;
    wr(8'h20, 8'h08); settle(2);
    rd(0, 8'h20, v); chk("R6 high-level idle", v & 8'h08, 0);
    rd(0, 8'h20, v); chk("R6 low-level pin4 set", v & 8'h10, 8'h10);
    @(negedge clk); pin_in[3] = 1'b1;
    settle(5);
    rd(0, 8'h20, v); chk("R6 high level sets", v & 8'h08, 8'h08);
    wr(8'h20, 8'h08);
    rd(0, 8'h20, v); chk("R6 re-set while held", v & 8'h08, 8'h08);
    @(negedge clk); pin_in[3] = 1'b0;
    settle(4);
    wr(8'h20, 8'h08); settle(2);
    rd(0, 8'h20, v); chk("R6 stays clear when low", v & 8'h08, 0);
  endtask

  task automatic t_w1c;
    logic [PW-1:0] v;
    wr(8'h19, 8'hFF); settle(1);
    wr(8'h21, 8'hFF); settle(1);
    rd(0, 8'h21, v); chk("R7 port1 cleared", v, 0);
    @(negedge clk); pin_in[8] = 1'b1;
    settle(5);
    rd(0, 8'h21, v); chk("R7 port1 rise", v, 8'h01);
    wr(8'h21, 8'h00);
    rd(0, 8'h21, v); chk("R7 write 0 no effect", v, 8'h01);
    wr(8'h21, 8'h01);
    rd(0, 8'h21, v); chk("R7 write 1 clears", v, 0);
  endtask

  task automatic t_summary;
    logic [PW-1:0] v;
    @(negedge clk); pin_in[0] = 1'b0; settle(4);
    wr(8'h20, 8'h01); wr(8'h1E, 8'h01); wr(8'h07, 8'h80);
    wr(8'h05, 8'h80); settle(1);
    rd(0, 8'h05, v); chk("R8 vendor idle", v, 0);
    chk("R9 alert idle", alert_n, 1);
    @(negedge clk); pin_in[0] = 1'b1;
    settle(6);
    rd(0, 8'h05, v); chk("R8 vendor set", v, 8'h80);
    chk("R9 alert low", alert_n, 0);
    wr(8'h05, 8'h80); settle(1);
    rd(0, 8'h05, v); chk("R8 no clear while pending", v, 8'h80);
    wr(8'h07, 8'h00); settle(1);
    chk("R9 masked summary releases", alert_n, 1);
    wr(8'h07, 8'h80);
    wr(8'h20, 8'h01); settle(1);
    wr(8'h05, 8'h80); settle(1);
    rd(0, 8'h05, v); chk("R8 vendor cleared", v, 0);
    chk("R9 alert released", alert_n, 1);
  endtask

  task automatic t_mux;
    logic [PW-1:0] v;
    wr(8'h02, 8'h0F);
    rd(0, 8'h02, v); chk("R10 mux read", v, 8'h0F);
    chk("R10 alt_sel", alt, 8'hF0);
  endtask

  task automatic t_lite;
    logic [PW-1:0] v;
    wr(8'h11, 8'hFF); settle(1);
    chk("R12 lite port1 oe", poe_l[15:8], 0);
    chk("R12 full port1 oe", poe[15:8], 8'hFF);
    rd(1, 8'h11, v); chk("R12 lite port1 read", v, 0);
    rd(1, 8'h10, v); chk("R12 lite port0 works", v, 8'hF0);
    @(negedge clk); pin_in[8] = 1'b0; settle(4);
    wr(8'h21, 8'hFF); wr(8'h1F, 8'h01); settle(1);
    wr(8'h05, 8'h80); settle(1);
    chk("R12 full alert idle", alert_n, 1);
    @(negedge clk); pin_in[8] = 1'b1;
    settle(6);
    chk("R12 full port1 alert", alert_n, 0);
    chk("R12 lite port1 no alert", alert_n_l, 1);
    rd(1, 8'h05, v); chk("R12 lite vendor clear", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_ident();
    t_drive();
    t_din();
    t_rise();
    t_fall();
    t_level();
    t_w1c();
    t_summary();
    t_mux();
    t_lite();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule